// File: doc/BRIEF.md
# Interleaved Page-Mode DRAM Slot Sequencer

This block runs a nibble-wide page-mode DRAM from a 16 MHz sub-cycle clock. Time is cut into slots of eight sub-cycles (500 ns). In each slot that has an owner, the block opens one row and strobes two columns in the same page. It joins the two 4-bit results into one byte, or writes one byte as two nibbles.

At the end of every slot the block decides who owns the next one: the video fetch, the CPU, or nobody. The choice depends on the bandwidth mode, the display-active flag, a slot parity that alternates, and an option that lets the CPU use every free slot. The same logic drives a CPU clock enable once per slot. That enable is withheld only when the CPU wants the lower half of the address space and does not own the slot. Accesses to the upper half are not served from this RAM, so they never wait.

A byte address of 15 bits maps onto the 8-bit multiplexed bus. The row is bits 14..7. The first column is bits 6..0 followed by a 0, and the second column is the same bits followed by a 1.

Top module: `dram_slot_seq`

## Requirements
- R1: Slots are 8 sub-cycles long and numbered phase 0 to 7, with phase 0 being the first edge after reset. In an owned slot, rasN is low in phases 1 to 6 and high in phases 7 and 0, so the row is precharged for two sub-cycles. In an idle slot, rasN stays high.
- R2: In an owned slot, casN is low only in phases 3 and 5. ramAddr carries the row (address bits 14..7) in phases 0 and 1. It carries column {bits 6..0, 0} in phases 2 and 3, and column {bits 6..0, 1} in phases 4 to 6.
- R3: For a read, the nibble present at the end of phase 4 becomes rdData bits 7..4, and the nibble at the end of phase 6 becomes bits 3..0. rdData holds the byte from phase 7 onward.
- R4: vidValid or cpuValid pulses for one sub-cycle in phase 7 of a slot owned by that requester. An idle slot gives no pulse and leaves all strobes high.
- R5: With hiBandwidth=1 and displayActive=1, video owns every slot. A CPU request below 0x8000 then receives no cpuClkEn. cpuClkEn is a one-sub-cycle pulse in phase 7.
- R6: With hiBandwidth=0 and displayActive=1, video owns the even slots and a pending lower-half CPU request owns the odd slots. The CPU is stalled in the video slots.
- R7: A CPU request with address bit 15 set takes no RAM slot, and cpuClkEn pulses in every slot.
- R8: With displayActive=0, a lower-half CPU request owns only the odd slots when fastCpu=0, and every slot when fastCpu=1. A request left without a slot gets no cpuClkEn. With no request, cpuClkEn pulses every slot.
- R9: In a CPU write slot, weN (active low, 1 = read) is low in phases 2 to 6. ramWdata carries cpuWdata bits 7..4 in phases 2 and 3 and bits 3..0 in phases 4 to 6. weN stays high in all other slots.
- R10: While rstN is low, rasN, casN and weN are high, and cpuClkEn, vidValid and cpuValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-cycle clock (16 MHz nominal) |
| rstN | input | 1 | Asynchronous reset, active low |
| hiBandwidth | input | 1 | 1: video takes every slot of an active line |
| fastCpu | input | 1 | 1: CPU may use every slot outside display activity |
| displayActive | input | 1 | Active part of a display line |
| vidAddr | input | 15 | Video fetch byte address |
| cpuReq | input | 1 | CPU memory access pending |
| cpuWrite | input | 1 | CPU access is a write |
| cpuAddr | input | 16 | CPU address; bit 15 selects the upper half |
| cpuWdata | input | 8 | CPU write byte |
| cpuClkEn | output | 1 | CPU clock enable pulse, phase 7 |
| rdData | output | 8 | Assembled read byte |
| vidValid | output | 1 | Video byte ready |
| cpuValid | output | 1 | CPU access done |
| ramAddr | output | 8 | Multiplexed DRAM address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ramWdata | output | 4 | Nibble driven to DRAM |
| ramRdata | input | 4 | Nibble returned by DRAM |

## Verification
The assertions check, on every cycle, the properties that concern the strobes alone. A column strobe never falls outside an open row, and each column strobe lasts a single sub-cycle. The row closes for at least one sub-cycle of precharge. Writes stay inside the open row. Valid pulses are single, exclusive, and fall in the precharge gap. A CPU-owned slot is never stalled. Which requester owns which slot in each mode, and whether a CPU is stalled, can only be shown by the bench scenarios. The same holds for the exact phase of each address, the nibble order of read and write bytes, and the full-rate behaviour of upper-half accesses. For these the bench compares against a behavioural DRAM and an ownership model.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_VID  = 2'd1,
    OWN_CPU  = 2'd2
  } slotOwner_t;

  typedef enum logic [1:0] {
    MUX_ROW  = 2'd0,
    MUX_COL1 = 2'd1,
    MUX_COL2 = 2'd2
  } muxSel_t;

  // Strobes from control to datapath. Fields other than capFirst/capSecond
  // describe the value each output register takes at the coming edge.
  typedef struct packed {
    logic       loadSlot;   // coming edge starts a new slot
    slotOwner_t owner;      // owner of the slot after the coming edge
    muxSel_t    muxSel;
    logic       rasN;
    logic       casN;
    logic       weN;
    logic       wrHigh;     // drive upper write nibble
    logic       capFirst;   // capture first nibble at this edge
    logic       capSecond;  // capture second nibble at this edge
    logic       vidValid;
    logic       cpuValid;
    logic       cpuClkEn;
  } seqCtl_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int SLOT_LEN = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hiBandwidth,
  input  logic    fastCpu,
  input  logic    displayActive,
  input  logic    cpuReq,
  input  logic    cpuWrite,
  input  logic    cpuUpper,
  output seqCtl_t ctl
);

  localparam int PH_W = $clog2(SLOT_LEN);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] PH_RAS    = PH_W'(1);
  localparam logic [PH_W-1:0] PH_COL1   = PH_W'(2);
  localparam logic [PH_W-1:0] PH_CAS1   = PH_W'(3);
  localparam logic [PH_W-1:0] PH_COL2   = PH_W'(4);
  localparam logic [PH_W-1:0] PH_CAS2   = PH_W'(5);
  localparam logic [PH_W-1:0] PH_CLOSE  = PH_W'(6);

  logic [PH_W-1:0] phase, phaseNext;
  slotOwner_t      owner, ownerNext;
  logic            slotOdd, slotOddNext;
  logic            cpuLow, cpuLowNext;
  logic            slotWr, slotWrNext;
  logic            slotEnd;
  logic            vidWins, cpuMay, cpuTakes;

  assign slotEnd   = (phase == PH_LAST);
  assign phaseNext = slotEnd ? '0 : phase + PH_W'(1);

  // Ownership of the coming slot
  always_comb begin
    slotOddNext = slotEnd ? ~slotOdd : slotOdd;
    vidWins     = displayActive && (hiBandwidth || !slotOddNext);
    cpuMay      = !vidWins && (slotOddNext || (fastCpu && !displayActive));
    cpuTakes    = cpuMay && cpuReq && !cpuUpper;
    if (slotEnd) begin
      if (vidWins)       ownerNext = OWN_VID;
      else if (cpuTakes) ownerNext = OWN_CPU;
      else               ownerNext = OWN_IDLE;
      cpuLowNext = cpuReq && !cpuUpper;
      slotWrNext = cpuTakes && cpuWrite;
    end else begin
      ownerNext  = owner;
      cpuLowNext = cpuLow;
      slotWrNext = slotWr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_LAST;
      owner   <= OWN_IDLE;
      slotOdd <= 1'b1;
      cpuLow  <= 1'b0;
      slotWr  <= 1'b0;
    end else begin
      phase   <= phaseNext;
      owner   <= ownerNext;
      slotOdd <= slotOddNext;
      cpuLow  <= cpuLowNext;
      slotWr  <= slotWrNext;
    end
  end

  // Strobe schedule for the coming sub-cycle
  logic busyNext, busyNow;
  assign busyNext = (ownerNext != OWN_IDLE);
  assign busyNow  = (owner != OWN_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.loadSlot = slotEnd;
    ctl.owner    = ownerNext;
    if (phaseNext < PH_COL1)      ctl.muxSel = MUX_ROW;
    else if (phaseNext < PH_COL2) ctl.muxSel = MUX_COL1;
    else if (phaseNext <= PH_CLOSE) ctl.muxSel = MUX_COL2;
    else                          ctl.muxSel = MUX_ROW;
    ctl.rasN      = !(busyNext && phaseNext >= PH_RAS && phaseNext <= PH_CLOSE);
    ctl.casN      = !(busyNext && (phaseNext == PH_CAS1 || phaseNext == PH_CAS2));
    ctl.weN       = !(busyNext && slotWrNext &&
                      phaseNext >= PH_COL1 && phaseNext <= PH_CLOSE);
    ctl.wrHigh    = (phaseNext < PH_COL2);
    ctl.capFirst  = busyNow && (phase == PH_COL2);
    ctl.capSecond = busyNow && (phase == PH_CLOSE);
    ctl.vidValid  = (phaseNext == PH_LAST) && (ownerNext == OWN_VID);
    ctl.cpuValid  = (phaseNext == PH_LAST) && (ownerNext == OWN_CPU);
    ctl.cpuClkEn  = (phaseNext == PH_LAST) &&
                    !(cpuLowNext && ownerNext != OWN_CPU);
  end

endmodule

// File: rtl/dram_seq_dpath.sv
module dram_seq_dpath
  import dram_seq_pkg::*;
#(
  parameter int MUX_W = 8,
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [2*MUX_W-2:0]   vidAddr,
  input  logic [2*MUX_W-2:0]   cpuAddr,
  input  logic [2*NIB_W-1:0]   cpuWdata,
  input  logic [NIB_W-1:0]     ramRdata,
  output logic [MUX_W-1:0]     ramAddr,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [NIB_W-1:0]     ramWdata,
  output logic [2*NIB_W-1:0]   rdData,
  output logic                 vidValid,
  output logic                 cpuValid,
  output logic                 cpuClkEn
);

  localparam int BYTE_AW = 2*MUX_W - 1;
  localparam int DATA_W  = 2*NIB_W;

  logic [BYTE_AW-1:0] slotAddr, addrSrc, pickAddr;
  logic [DATA_W-1:0]  slotWdata, dataSrc;
  logic [NIB_W-1:0]   nibHi;
  logic [MUX_W-1:0]   rowBits, colBits1, colBits2, muxOut;

  assign pickAddr = (ctl.owner == OWN_VID) ? vidAddr : cpuAddr;
  assign addrSrc  = ctl.loadSlot ? pickAddr : slotAddr;
  assign dataSrc  = ctl.loadSlot ? cpuWdata : slotWdata;

  assign rowBits  = addrSrc[BYTE_AW-1:MUX_W-1];
  assign colBits1 = {addrSrc[MUX_W-2:0], 1'b0};
  assign colBits2 = {addrSrc[MUX_W-2:0], 1'b1};

  always_comb begin
    unique case (ctl.muxSel)
      MUX_COL1: muxOut = colBits1;
      MUX_COL2: muxOut = colBits2;
      default:  muxOut = rowBits;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotAddr  <= '0;
      slotWdata <= '0;
      ramAddr   <= '0;
      rasN      <= 1'b1;
      casN      <= 1'b1;
      weN       <= 1'b1;
      ramWdata  <= '0;
      nibHi     <= '0;
      rdData    <= '0;
      vidValid  <= 1'b0;
      cpuValid  <= 1'b0;
      cpuClkEn  <= 1'b0;
    end else begin
      if (ctl.loadSlot) begin
        slotAddr  <= pickAddr;
        slotWdata <= cpuWdata;
      end
      ramAddr  <= muxOut;
      rasN     <= ctl.rasN;
      casN     <= ctl.casN;
      weN      <= ctl.weN;
      ramWdata <= ctl.wrHigh ? dataSrc[DATA_W-1:NIB_W] : dataSrc[NIB_W-1:0];
      if (ctl.capFirst)  nibHi  <= ramRdata;
      if (ctl.capSecond) rdData <= {nibHi, ramRdata};
      vidValid <= ctl.vidValid;
      cpuValid <= ctl.cpuValid;
      cpuClkEn <= ctl.cpuClkEn;
    end
  end

endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dram_seq_pkg::*;
#(
  parameter int MUX_W = 8,
  parameter int NIB_W = 4,
  localparam int BYTE_AW = 2*MUX_W - 1,
  localparam int CPU_AW  = BYTE_AW + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hiBandwidth,
  input  logic                 fastCpu,
  input  logic                 displayActive,
  input  logic [BYTE_AW-1:0]   vidAddr,
  input  logic                 cpuReq,
  input  logic                 cpuWrite,
  input  logic [CPU_AW-1:0]    cpuAddr,
  input  logic [2*NIB_W-1:0]   cpuWdata,
  output logic                 cpuClkEn,
  output logic [2*NIB_W-1:0]   rdData,
  output logic                 vidValid,
  output logic                 cpuValid,
  output logic [MUX_W-1:0]     ramAddr,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [NIB_W-1:0]     ramWdata,
  input  logic [NIB_W-1:0]     ramRdata
);

  seqCtl_t ctl;

  dram_seq_ctrl #(.SLOT_LEN(8)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hiBandwidth   (hiBandwidth),
    .fastCpu       (fastCpu),
    .displayActive (displayActive),
    .cpuReq        (cpuReq),
    .cpuWrite      (cpuWrite),
    .cpuUpper      (cpuAddr[CPU_AW-1]),
    .ctl           (ctl)
  );

  dram_seq_dpath #(.MUX_W(MUX_W), .NIB_W(NIB_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .vidAddr  (vidAddr),
    .cpuAddr  (cpuAddr[BYTE_AW-1:0]),
    .cpuWdata (cpuWdata),
    .ramRdata (ramRdata),
    .ramAddr  (ramAddr),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ramWdata (ramWdata),
    .rdData   (rdData),
    .vidValid (vidValid),
    .cpuValid (cpuValid),
    .cpuClkEn (cpuClkEn)
  );

endmodule

// File: rtl/dram_slot_seq_checker.sv
module dram_slot_seq_checker (
  input logic clk,
  input logic rstN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic vidValid,
  input logic cpuValid,
  input logic cpuClkEn
);

  assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  assert_cas_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    !casN |=> casN);

  assert_precharge_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |=> rasN);

  assert_write_in_row_R9: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !rasN);

  assert_one_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(vidValid && cpuValid));

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidValid || cpuValid) |=> !(vidValid || cpuValid));

  assert_valid_in_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (vidValid || cpuValid) |-> (rasN && casN && weN));

  assert_owner_not_stalled_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> cpuClkEn);

  assert_clken_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |=> !cpuClkEn);

endmodule

bind dram_slot_seq dram_slot_seq_checker chk (
  .clk      (clk),
  .rstN     (rstN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .vidValid (vidValid),
  .cpuValid (cpuValid),
  .cpuClkEn (cpuClkEn)
);

// File: tb/dram_slot_seq_test.sv
`timescale 1ns/1ps
module dram_slot_seq_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN;
  logic        hiBandwidth, fastCpu, displayActive;
  logic [14:0] vidAddr;
  logic        cpuReq, cpuWrite;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWdata;
  logic        cpuClkEn, vidValid, cpuValid;
  logic [7:0]  rdData;
  logic [7:0]  ramAddr;
  logic        rasN, casN, weN;
  logic [3:0]  ramWdata, ramRdata;

  dram_slot_seq uut (
    .clk(clk), .rstN(rstN), .hiBandwidth(hiBandwidth), .fastCpu(fastCpu),
    .displayActive(displayActive), .vidAddr(vidAddr), .cpuReq(cpuReq),
    .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuClkEn(cpuClkEn), .rdData(rdData), .vidValid(vidValid),
    .cpuValid(cpuValid), .ramAddr(ramAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // Behavioural DRAM: latch row and column on strobe falls
  logic [7:0] rowL = 8'h00, colL = 8'h00;
  always @(negedge rasN) rowL = ramAddr;
  always @(negedge casN) colL = ramAddr;

  function automatic logic [3:0] cellVal(logic [7:0] r, logic [7:0] c);
    return r[3:0] ^ r[7:4] ^ c[3:0] ^ c[7:4] ^ 4'h5;
  endfunction
  assign ramRdata = cellVal(rowL, colL);

  typedef struct {
    int          owner;   // 0 idle, 1 video, 2 cpu
    logic [14:0] addr;
    logic        wr;
    logic [7:0]  wdata;
    logic        clkEn;
    string       ownTag;
    string       clkTag;
  } slotExp_t;

  slotExp_t expQ[$];
  slotExp_t cur;
  int checks = 0, errors = 0;
  int cyc = 0, decisions = 0;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Driver side: push the expected outcome of the coming slot
  task automatic pushNext();
    slotExp_t e;
    bit odd, low, vid, cpu;
    odd = decisions[0];
    low = cpuReq && !cpuAddr[15];
    vid = displayActive && (hiBandwidth || !odd);
    cpu = !vid && low && (odd || (fastCpu && !displayActive));
    e.owner  = vid ? 1 : (cpu ? 2 : 0);
    e.addr   = vid ? vidAddr : cpuAddr[14:0];
    e.wr     = cpu && cpuWrite;
    e.wdata  = cpuWdata;
    e.clkEn  = !(low && !cpu);
    e.ownTag = !displayActive ? "R8" : (hiBandwidth ? "R5" : "R6");
    if (e.owner == 0) e.ownTag = "R4";
    e.clkTag = (cpuReq && cpuAddr[15]) ? "R7" :
               (!displayActive ? "R8" : (hiBandwidth ? "R5" : "R6"));
    expQ.push_back(e);
    decisions++;
  endtask

  task automatic slotCheck(int p);
    bit act;
    logic [7:0] expA;
    act = (cur.owner != 0);
    check(rasN == !(act && p >= 1 && p <= 6), "R1", "rasN", rasN, !(act && p >= 1 && p <= 6));
    check(casN == !(act && (p == 3 || p == 5)), "R2", "casN", casN, !(act && (p == 3 || p == 5)));
    check(weN == !(act && cur.wr && p >= 2 && p <= 6), "R9", "weN", weN,
          !(act && cur.wr && p >= 2 && p <= 6));
    if (act && p <= 6) begin
      if (p <= 1)      expA = cur.addr[14:7];
      else if (p <= 3) expA = {cur.addr[6:0], 1'b0};
      else             expA = {cur.addr[6:0], 1'b1};
      check(ramAddr == expA, "R2", "ramAddr", ramAddr, expA);
    end
    if (act && cur.wr && p >= 2 && p <= 6) begin
      expA = (p <= 3) ? {4'h0, cur.wdata[7:4]} : {4'h0, cur.wdata[3:0]};
      check(ramWdata == expA[3:0], "R9", "ramWdata", ramWdata, expA);
    end
    if (p == 7) begin
      check(vidValid == (cur.owner == 1), cur.ownTag, "vidValid", vidValid, cur.owner == 1);
      check(cpuValid == (cur.owner == 2), cur.ownTag, "cpuValid", cpuValid, cur.owner == 2);
      check(cpuClkEn == cur.clkEn, cur.clkTag, "cpuClkEn", cpuClkEn, cur.clkEn);
      if (act && !cur.wr) begin
        expA = {cellVal(cur.addr[14:7], {cur.addr[6:0], 1'b0}),
                cellVal(cur.addr[14:7], {cur.addr[6:0], 1'b1})};
        check(rdData == expA, "R3", "rdData", rdData, expA);
      end
    end else begin
      check(!vidValid && !cpuValid, "R4", "valid outside phase 7", {vidValid, cpuValid}, 0);
      check(!cpuClkEn, "R5", "cpuClkEn outside phase 7", cpuClkEn, 0);
    end
  endtask

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  // Monitor: pop at slot start, compare every sub-cycle
  always @(negedge clk) begin
    if (rstN) begin
      int p;
      p = (cyc + 7) % 8;
      if (cyc > 0) begin
        if (p == 0) begin
          if (expQ.size() == 0) check(0, "R1", "missing expectation", 0, 1);
          else cur = expQ.pop_front();
        end
        slotCheck(p);
      end
      if (p == 7) pushNext();
    end
  end

  task automatic atPhase3();
    do @(negedge clk); while (((cyc + 7) % 8) != 3);
  endtask

  task automatic runSlots(int n);
    for (int i = 0; i < n; i++) begin
      atPhase3();
      vidAddr       = vidAddr + 15'h0123;
      cpuAddr[14:0] = cpuAddr[14:0] + 15'h0457;
      cpuWdata      = cpuWdata + 8'h3b;
    end
  endtask

  task automatic setMode(bit d, bit h, bit f, bit req, bit wr, bit upper);
    atPhase3();
    displayActive = d; hiBandwidth = h; fastCpu = f;
    cpuReq = req; cpuWrite = wr; cpuAddr[15] = upper;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    hiBandwidth = 0; fastCpu = 0; displayActive = 1;
    vidAddr = 15'h1234; cpuReq = 1; cpuWrite = 0;
    cpuAddr = 16'h0a5c; cpuWdata = 8'hc3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(rasN && casN && weN, "R10", "strobes in reset", {rasN, casN, weN}, 3'b111);
    check(!cpuClkEn && !vidValid && !cpuValid, "R10", "pulses in reset",
          {cpuClkEn, vidValid, cpuValid}, 0);
    @(posedge clk); #1 rstN = 1'b1;

    runSlots(6);                   // R6 low bandwidth, active line, lower reads
    setMode(1, 1, 0, 1, 0, 0);     // R5 high bandwidth: video only, CPU stalled
    runSlots(5);
    setMode(1, 1, 0, 1, 0, 1);     // R7 upper access at full rate
    runSlots(4);
    setMode(0, 0, 0, 1, 0, 0);     // R8 inactive, every other slot
    runSlots(6);
    setMode(0, 0, 1, 1, 0, 0);     // R8 fast mode: every slot
    runSlots(5);
    setMode(0, 0, 1, 1, 1, 0);     // R9 writes
    runSlots(5);
    setMode(0, 0, 0, 0, 0, 0);     // R4 idle slots
    runSlots(4);
    setMode(1, 0, 1, 1, 1, 0);     // R6 low bandwidth with writes, fast ignored
    runSlots(6);
    runSlots(2);
    finishRun();
  end

endmodule